// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Unit

This block executes the prefixed bit-manipulation instruction group of an 8-bit processor core on a single operand. Each request carries the prefixed opcode byte, the operand value and the current flags. The block returns the new operand value, the new flags, a flag saying whether the value must be written back, and the number of machine cycles the instruction costs. Fetching the operand from a register or from memory, and recognising the prefix byte itself, are left to the surrounding core.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, with one register stage between them. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output one cycle later. The result stays there, unchanged, until a rising edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. This means a consumer that holds `out_ready` high can take one result every cycle. A consumer that drops `out_ready` stalls the producer without losing anything.

Top module: `cbx_unit`

## Requirements
- R1: Opcode bits 7:6 select the group: 0 is rotate/shift, 1 is bit test, 2 is bit clear and 3 is bit set. Bits 5:3 hold the shift kind or the bit index. Bits 2:0 hold the operand index.
- R2: Shift kind 0 rotates left and kind 1 rotates right. In both, the bit leaving one end goes into the vacated bit at the other end and also into C.
- R3: Shift kind 2 rotates left through carry and kind 3 rotates right through carry. The old C fills the vacated bit and the bit shifted out becomes the new C.
- R4: Shift kind 4 shifts left and fills bit 0 with zero. Kind 5 shifts right and keeps bit 7. Kind 7 shifts right and fills bit 7 with zero. In all three, C takes the bit shifted out.
- R5: Every rotate and shift kind clears N and H and sets Z exactly when the result is zero. Flags are encoded as bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C.
- R6: Shift kind 6 exchanges the two nibbles, clears N, H and C, and sets Z when the result is zero.
- R7: Bit test sets Z when the selected bit of the operand is zero. It sets H, clears N and keeps C. It returns the operand unchanged with the write-back flag low.
- R8: Bit clear and bit set change only the selected bit, return all four flags unchanged and raise the write-back flag. The rotate and shift group also raises the write-back flag.
- R9: The cycle count is 2 for operand indices other than 6. For operand index 6, it is 4, except for bit test, which reports 3.
- R10: A request accepted on an edge is visible on the output after that edge. A result that is valid but not accepted keeps all output fields stable. `in_ready` equals `!out_valid || out_ready`.
- R11: During and just after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_opcode | input | 8 | Prefixed opcode byte |
| in_operand | input | 8 | Operand value |
| in_flags | input | 4 | Incoming flags {Z,N,H,C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | New operand value |
| out_flags | output | 4 | New flags {Z,N,H,C} |
| out_wb | output | 1 | Result must be written back |
| out_cycles | output | 3 | Machine cycles for the instruction |

## Verification
The only state is the output register, so any fault appears at the ports one cycle after the request that caused it. Wrong field decoding, a wrong carry path or a wrong cycle rule shows as a miscompare on the very next transfer. A fault in the handshake works differently: it shows as a result that changes during a stall, or as a transfer that is lost or duplicated. The bench catches that either through the stability check or through a mismatch between the expected queue and the results it receives. Every opcode is swept under several operand and flag patterns while `out_ready` toggles pseudo-randomly, so both fault kinds are exposed within the run.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

  localparam int OP_W   = 8;
  localparam int FLAG_W = 4;

  // flag bit positions in the {Z,N,H,C} vector
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SK_ROL  = 3'd0,
    SK_ROR  = 3'd1,
    SK_RCL  = 3'd2,
    SK_RCR  = 3'd3,
    SK_SHL  = 3'd4,
    SK_SAR  = 3'd5,
    SK_SWP  = 3'd6,
    SK_SHR  = 3'd7
  } shkind_e;

endpackage

// File: rtl/cbx_decode.sv
module cbx_decode
  import cbx_pkg::*;
#(
  parameter int CYC_W        = 3,
  parameter int CYC_REG      = 2,
  parameter int CYC_MEM      = 4,
  parameter int CYC_MEM_TEST = 3,
  parameter int MEM_IDX      = 6
) (
  input  logic [OP_W-1:0]  opcode,
  output grp_e             grp,
  output logic [2:0]       sel,
  output logic [CYC_W-1:0] cycles
);

  logic [2:0] idx;
  logic       is_mem;

  // R1: field split of the opcode byte
  assign grp    = grp_e'(opcode[7:6]);
  assign sel    = opcode[5:3];
  assign idx    = opcode[2:0];
  assign is_mem = (idx == 3'(MEM_IDX));

  // R9: cycle cost, reduced for a memory bit test that skips write-back
  always_comb begin
    if (!is_mem)
      cycles = CYC_W'(CYC_REG);
    else if (grp == GRP_TEST)
      cycles = CYC_W'(CYC_MEM_TEST);
    else
      cycles = CYC_W'(CYC_MEM);
  end

endmodule

// File: rtl/cbx_shifter.sv
module cbx_shifter
  import cbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic              cin,
  input  shkind_e           kind,
  output logic [DATA_W-1:0] dout,
  output logic              cout
);

  localparam int HALF_W = DATA_W / 2;

  logic msb, lsb;
  assign msb = din[DATA_W-1];
  assign lsb = din[0];

  always_comb begin
    dout = din;
    cout = 1'b0;
    unique case (kind)
      SK_ROL: begin dout = {din[DATA_W-2:0], msb};  cout = msb; end   // R2
      SK_ROR: begin dout = {lsb, din[DATA_W-1:1]};  cout = lsb; end   // R2
      SK_RCL: begin dout = {din[DATA_W-2:0], cin};  cout = msb; end   // R3
      SK_RCR: begin dout = {cin, din[DATA_W-1:1]};  cout = lsb; end   // R3
      SK_SHL: begin dout = {din[DATA_W-2:0], 1'b0}; cout = msb; end   // R4
      SK_SAR: begin dout = {msb, din[DATA_W-1:1]};  cout = lsb; end   // R4
      SK_SWP: begin
        dout = {din[HALF_W-1:0], din[DATA_W-1:HALF_W]};               // R6
        cout = 1'b0;
      end
      SK_SHR: begin dout = {1'b0, din[DATA_W-1:1]}; cout = lsb; end   // R4
      default: begin dout = din; cout = 1'b0; end
    endcase
  end

endmodule

// File: rtl/cbx_bitop.sv
module cbx_bitop
  import cbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]         din,
  input  logic [$clog2(DATA_W)-1:0] sel,
  input  logic                      set_not_clr,
  output logic [DATA_W-1:0]         dout,
  output logic                      sel_bit
);

  logic [DATA_W-1:0] mask;

  // one-hot mask built per bit position
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (sel == ($clog2(DATA_W))'(i));
  end

  assign sel_bit = |(din & mask);
  // R8: only the masked bit is touched
  assign dout    = set_not_clr ? (din | mask) : (din & ~mask);

endmodule

// File: rtl/cbx_unit.sv
module cbx_unit
  import cbx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CYC_W        = 3,
  parameter int CYC_REG      = 2,
  parameter int CYC_MEM      = 4,
  parameter int CYC_MEM_TEST = 3,
  parameter int MEM_IDX      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_opcode,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_wb,
  output logic [CYC_W-1:0]  out_cycles
);

  localparam int SEL_W = $clog2(DATA_W);

  grp_e              grp;
  logic [2:0]        sel;
  logic [CYC_W-1:0]  cyc_n;
  logic [DATA_W-1:0] sh_res, bo_res, res_n;
  logic              sh_cout, sel_bit;
  logic [FLAG_W-1:0] flg_n;
  logic              wb_n;
  logic              fire_in;

  cbx_decode #(
    .CYC_W(CYC_W), .CYC_REG(CYC_REG), .CYC_MEM(CYC_MEM),
    .CYC_MEM_TEST(CYC_MEM_TEST), .MEM_IDX(MEM_IDX)
  ) u_dec (
    .opcode (in_opcode),
    .grp    (grp),
    .sel    (sel),
    .cycles (cyc_n)
  );

  cbx_shifter #(.DATA_W(DATA_W)) u_sh (
    .din  (in_operand),
    .cin  (in_flags[FC]),
    .kind (shkind_e'(sel)),
    .dout (sh_res),
    .cout (sh_cout)
  );

  cbx_bitop #(.DATA_W(DATA_W)) u_bo (
    .din         (in_operand),
    .sel         (SEL_W'(sel)),
    .set_not_clr (grp == GRP_SET),
    .dout        (bo_res),
    .sel_bit     (sel_bit)
  );

  always_comb begin
    res_n = in_operand;
    flg_n = in_flags;
    wb_n  = 1'b1;
    unique case (grp)
      GRP_SHIFT: begin  // R5 / R6
        res_n     = sh_res;
        flg_n     = '0;
        flg_n[FZ] = (sh_res == '0);
        flg_n[FC] = sh_cout;
      end
      GRP_TEST: begin   // R7
        res_n     = in_operand;
        flg_n[FZ] = ~sel_bit;
        flg_n[FN] = 1'b0;
        flg_n[FH] = 1'b1;
        wb_n      = 1'b0;
      end
      default: begin    // R8
        res_n = bo_res;
      end
    endcase
  end

  // R10: single output stage with pass-through ready
  assign in_ready = !out_valid || out_ready;
  assign fire_in  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      out_wb     <= 1'b0;
      out_cycles <= '0;
    end else begin
      if (fire_in) begin
        out_valid  <= 1'b1;
        out_result <= res_n;
        out_flags  <= flg_n;
        out_wb     <= wb_n;
        out_cycles <= cyc_n;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  a_r7_test_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && in_opcode[7:6] == 2'b01) |=> (out_valid && !out_wb));

  a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && in_opcode[7]) |=> (out_flags == $past(in_flags) && out_wb));

  a_r9_reg_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && in_opcode[2:0] != 3'(MEM_IDX)) |=> (out_cycles == CYC_W'(CYC_REG)));

  a_r6_swap_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && in_opcode[7:3] == 5'b00110) |=> (!out_flags[FC] && !out_flags[FN] && !out_flags[FH]));

  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)
                                   && $stable(out_wb) && $stable(out_cycles)));

endmodule

// File: tb/cbx_unit_tb_top.sv
module cbx_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_opcode = '0;
  logic [7:0] in_operand = '0;
  logic [3:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic [3:0] out_flags;
  logic       out_wb;
  logic [2:0] out_cycles;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cbx_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_operand(in_operand), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags),
    .out_wb(out_wb), .out_cycles(out_cycles)
  );

  // expected packed as {result[15:8], flags[7:4], wb[3], cycles[2:0]}
  logic [15:0] exp_q[$];
  logic [7:0]  op_q[$];

  function automatic logic [15:0] model(input logic [7:0] op, input logic [7:0] d,
                                        input logic [3:0] f);
    int g = op[7:6];
    int k = op[5:3];
    int ix = op[2:0];
    int r = d;
    int z, n, h, c;
    int wb = 1;
    int cy;
    z = f[3]; n = f[2]; h = f[1]; c = f[0];
    if (g == 0) begin
      case (k)
        0: begin c = d[7]; r = ((d * 2) % 256) + d[7]; end
        1: begin c = d[0]; r = (d / 2) + d[0] * 128; end
        2: begin r = ((d * 2) % 256) + f[0]; c = d[7]; end
        3: begin r = (d / 2) + f[0] * 128; c = d[0]; end
        4: begin c = d[7]; r = (d * 2) % 256; end
        5: begin c = d[0]; r = (d / 2) + d[7] * 128; end
        6: begin c = 0; r = (d % 16) * 16 + d / 16; end
        default: begin c = d[0]; r = d / 2; end
      endcase
      z = (r == 0); n = 0; h = 0;
    end else if (g == 1) begin
      z = (((d >> k) & 1) == 0); n = 0; h = 1; wb = 0;
    end else if (g == 2) begin
      r = d & ~(1 << k) & 255;
    end else begin
      r = d | (1 << k);
    end
    if (ix != 6) cy = 2;
    else if (g == 1) cy = 3;
    else cy = 4;
    model = {8'(r), 1'(z), 1'(n), 1'(h), 1'(c), 1'(wb), 3'(cy)};
  endfunction

  function automatic string req_of(input logic [7:0] op);
    if (op[7:6] == 2'd1) return "R7";
    if (op[7]) return "R8";
    case (op[5:3])
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd6:       return "R6";
      default:    return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin : stim
    logic [7:0]  pats [6];
    logic [15:0] snap;
    bit          stalled = 1'b0;
    int          sent = 0;
    int          total = 256 * 6;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] e;
    logic [7:0]  o;
    logic [15:0] act;

    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11", {15'd0, out_valid}, 16'd0);
    check("R11", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {15'd0, out_valid}, 16'd0);

    while (sent < total || exp_q.size() != 0) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      if (sent < total) begin
        int op = sent % 256;
        int p  = sent / 256;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h80;
        pats[3] = 8'h01; pats[4] = 8'hA5; pats[5] = 8'(op) ^ 8'h5A;
        in_valid   = 1'b1;
        in_opcode  = 8'(op);
        in_operand = pats[p];
        in_flags   = 4'(p * 5 + op);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      act = {out_result, out_flags, out_wb, out_cycles};
      // R10: a stalled result must not move
      if (stalled) check("R10", act, snap);
      // R10: ready rule
      check("R10", {15'd0, in_ready}, {15'd0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R10", 16'hDEAD, 16'h0000);
        end else begin
          e = exp_q.pop_front();
          o = op_q.pop_front();
          check(req_of(o), {act[15:8], 8'h00}, {e[15:8], 8'h00});
          check(o[7:6] == 2'd0 ? "R5" : req_of(o), {12'd0, act[7:4]}, {12'd0, e[7:4]});
          check(o[7:6] == 2'd1 ? "R7" : "R8", {15'd0, act[3]}, {15'd0, e[3]});
          check("R9", {13'd0, act[2:0]}, {13'd0, e[2:0]}); // R1 index field drives this
        end
      end
      stalled = out_valid && !out_ready;
      snap    = act;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_opcode, in_operand, in_flags));
        op_q.push_back(in_opcode);
        sent++;
      end
      @(negedge clk);
    end
    // R10: once drained, nothing is left valid
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    check("R10", {15'd0, out_valid}, 16'd0);
    done = 1'b1;
    finish_run();
  end

endmodule